// File: doc/BRIEF.md
# Secure Boot Handshake Sequencer

This block sits on the security-processor side of a two-core boot. The application core sends it typed messages. Each message is a 4-bit type code plus one payload word. The sequencer answers with typed messages of its own. It runs the secure-boot order:
1. It waits for a greeting.
2. It takes a certificate and has an external engine validate it.
3. It feeds each image chunk to an external hash engine as the chunk arrives.
4. After the final chunk it asks a compare engine to check the digest against the certificate.
5. If the certificate asks for it, it then runs a decrypt engine.

Each external engine is reached through a start pulse and a done/pass reply. All engines share one argument word, `job_word`. A single `eng_abort` pulse cancels whichever engine is running.

Both message ports are valid/ready. A word moves on the inbound port only in a cycle where `in_valid` and `in_ready` are both high. A word moves on the outbound port only in a cycle where `out_valid` and `out_ready` are both high. The outbound port holds exactly one reply. While that reply is waiting, and while an engine result is waiting to be handled, `in_ready` is low. This back-pressures the sender instead of dropping its messages.

Any failure sends a fail RESULT and returns the sequencer to waiting for a certificate. After a pass RESULT, the sequencer waits for the result acknowledge. It then issues a one-cycle reset pulse to the application core with boot vector 0, and stops accepting messages.

Top module: `boot_handshake_seq`

## Requirements
- R1: After reset `in_ready`=1, `out_valid`=0, `app_rst`=0 and `err_flag`=0. The first accepted state needs HELLO before anything else.
- R2: Type codes are: HELLO=1, CERT=2, IMAGE=3, GET_SOC_ID=4, RESULT_ACK=5, CANCEL=6, SOC_ID=8, RESULT=9, CANCEL_ACK=10. A RESULT carries its code in payload bits [1:0]: 0 pass, 1 certificate fail, 2 hash mismatch, 3 decrypt fail.
- R3: While `out_valid`=1 and `out_ready`=0, `out_type` and `out_data` stay stable. While `out_valid`=1, `in_ready`=0.
- R4: An accepted CERT loads its payload into `job_word`. It raises `cert_start` for exactly one cycle, starting the cycle after acceptance. A certificate fail yields RESULT code 1.
- R5: Each accepted IMAGE chunk gives one `hash_start` pulse, with `job_word` equal to the chunk payload. The next chunk is taken only after `hash_done`.
- R6: `cmp_start` fires only after the hash of the chunk marked `in_last` has completed. A mismatch yields RESULT code 2.
- R7: `dec_start` fires only when the certificate's decrypt flag (`cert_decrypt`, sampled with `cert_done`) is set and the compare has passed. A decrypt fail yields RESULT code 3. With the flag clear, a passing compare yields RESULT code 0 at once.
- R8: After RESULT code 0, only RESULT_ACK leads to `app_rst`. The pulse lasts one cycle with `app_boot_vec`=0. After it, `in_ready` stays 0.
- R9: GET_SOC_ID in any state after HELLO is answered with SOC_ID carrying `soc_id`, and the state does not change.
- R10: CANCEL in any certificate or image state pulses `eng_abort` in the following cycle. It answers CANCEL_ACK with payload 0 and returns to waiting for a certificate. A done from the aborted engine is ignored.
- R11: A message type not valid in the current state is consumed without any reply. It sets `err_flag`, which stays set until reset.
- R12: An engine result that arrives while a reply is waiting is held. It is acted on after the reply drains, and its RESULT follows that reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound message valid |
| in_ready | output | 1 | Inbound message ready |
| in_type | input | 4 | Inbound message type |
| in_data | input | DW | Inbound payload |
| in_last | input | 1 | Marks the final IMAGE chunk |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound message ready |
| out_type | output | 4 | Outbound message type |
| out_data | output | DW | Outbound payload |
| soc_id | input | DW | Identity word returned in SOC_ID |
| job_word | output | DW | Argument for the certificate and hash engines |
| cert_start | output | 1 | Certificate engine start pulse |
| cert_done | input | 1 | Certificate engine done |
| cert_pass | input | 1 | Certificate valid, with done |
| cert_decrypt | input | 1 | Certificate requests decryption, with done |
| hash_start | output | 1 | Hash engine chunk start pulse |
| hash_done | input | 1 | Hash engine chunk done |
| cmp_start | output | 1 | Digest compare start pulse |
| cmp_done | input | 1 | Compare done |
| cmp_pass | input | 1 | Digest matched, with done |
| dec_start | output | 1 | Decrypt engine start pulse |
| dec_done | input | 1 | Decrypt done |
| dec_pass | input | 1 | Decrypt succeeded, with done |
| eng_abort | output | 1 | Abort pulse to all engines |
| app_rst | output | 1 | One-cycle reset to the application core |
| app_boot_vec | output | VW | Boot vector for the application core, always 0 |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The assertions assume the following about the inputs:
- An engine raises done only after its own start and before any abort.
- The compare engine's done/pass reflects a digest of the current certificate's image.
- The inbound sender keeps type, payload and last flag steady while valid is high.

The stimulus meets these as follows. It drives inputs only at falling edges. It holds a message until `in_ready` is seen. It answers each engine only after observing that engine's start pulse. The one exception is a deliberately late certificate done after an abort, which the design must ignore.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [3:0] {
    M_NONE = 4'd0, M_HELLO = 4'd1, M_CERT = 4'd2, M_IMAGE = 4'd3,
    M_GETID = 4'd4, M_RACK = 4'd5, M_CANCEL = 4'd6,
    M_SOCID = 4'd8, M_RESULT = 4'd9, M_CACK = 4'd10
  } msg_e;

  typedef enum logic [3:0] {
    S_HELLO, S_WCERT, S_CERT_RUN, S_WIMG, S_HASH_RUN,
    S_CMP_RUN, S_DEC_RUN, S_WRACK, S_APPRST, S_DONE
  } st_e;

  localparam int NENG     = 4;
  localparam int E_CERT   = 0;
  localparam int E_HASH   = 1;
  localparam int E_CMP    = 2;
  localparam int E_DEC    = 3;

  localparam logic [1:0] RC_PASS = 2'd0;
  localparam logic [1:0] RC_CERT = 2'd1;
  localparam logic [1:0] RC_HASH = 2'd2;
  localparam logic [1:0] RC_DEC  = 2'd3;
endpackage

// File: rtl/hs_engine_port.sv
// Start/done tracker for one external engine: one-cycle start, busy until
// done or abort, result held until the sequencer consumes it.
module hs_engine_port (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic abort,
  input  logic done,
  input  logic pass,
  input  logic consume,
  output logic start,
  output logic busy,
  output logic fin,
  output logic ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start <= 1'b0;
      busy  <= 1'b0;
      fin   <= 1'b0;
      ok    <= 1'b0;
    end else begin
      start <= launch && !abort;
      if (abort) begin
        busy <= 1'b0;
        fin  <= 1'b0;
      end else if (launch) begin
        busy <= 1'b1;
        fin  <= 1'b0;
      end else if (busy && done) begin
        busy <= 1'b0;
        fin  <= 1'b1;
        ok   <= pass;
      end else if (consume) begin
        fin <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_outbox.sv
// Single-entry outbound message holder with valid/ready drain.
module hs_outbox #(
  parameter int DW = 32,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post,
  input  logic [TW-1:0] post_type,
  input  logic [DW-1:0] post_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [TW-1:0] out_type,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_data  <= '0;
    end else if (post) begin
      out_valid <= 1'b1;
      out_type  <= post_type;
      out_data  <= post_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_handshake_seq.sv
module boot_handshake_seq
  import hs_pkg::*;
#(
  parameter int DW = 32,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_type,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    out_type,
  output logic [DW-1:0] out_data,
  input  logic [DW-1:0] soc_id,
  output logic [DW-1:0] job_word,
  output logic          cert_start,
  input  logic          cert_done,
  input  logic          cert_pass,
  input  logic          cert_decrypt,
  output logic          hash_start,
  input  logic          hash_done,
  output logic          cmp_start,
  input  logic          cmp_done,
  input  logic          cmp_pass,
  output logic          dec_start,
  input  logic          dec_done,
  input  logic          dec_pass,
  output logic          eng_abort,
  output logic          app_rst,
  output logic [VW-1:0] app_boot_vec,
  output logic          err_flag
);
  localparam logic [VW-1:0] BOOT_VEC = '0;

  st_e             state, nxt;
  logic            dec_en, last_q;
  logic            acc, fin_any, ok_any, consume, abort, err_set, post;
  logic            last_n, load_job;
  logic [3:0]      ptype;
  logic [DW-1:0]   pdata;
  logic [NENG-1:0] launch, e_start, e_busy, e_fin, e_ok, e_done, e_pass;

  assign e_done = {dec_done, cmp_done, hash_done, cert_done};
  assign e_pass = {dec_pass, cmp_pass, 1'b1, cert_pass};

  for (genvar g = 0; g < NENG; g++) begin : g_eng
    hs_engine_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch[g]),
      .abort  (abort),
      .done   (e_done[g]),
      .pass   (e_pass[g]),
      .consume(consume),
      .start  (e_start[g]),
      .busy   (e_busy[g]),
      .fin    (e_fin[g]),
      .ok     (e_ok[g])
    );
  end

  assign cert_start = e_start[E_CERT];
  assign hash_start = e_start[E_HASH];
  assign cmp_start  = e_start[E_CMP];
  assign dec_start  = e_start[E_DEC];

  assign fin_any  = |e_fin;
  assign ok_any   = |(e_fin & e_ok);
  assign in_ready = !out_valid && !fin_any && (state != S_APPRST) && (state != S_DONE);
  assign acc      = in_valid && in_ready;

  hs_outbox #(.DW(DW), .TW(4)) u_outbox (
    .clk      (clk),
    .rst_n    (rst_n),
    .post     (post),
    .post_type(ptype),
    .post_data(pdata),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_type (out_type),
    .out_data (out_data)
  );

  function automatic logic [DW-1:0] rcode(input logic [1:0] c);
    logic [DW-1:0] w;
    w = '0;
    w[1:0] = c;
    return w;
  endfunction

  function automatic logic cancel_state(input st_e s);
    return (s == S_WCERT) || (s == S_CERT_RUN) || (s == S_WIMG) ||
           (s == S_HASH_RUN) || (s == S_CMP_RUN) || (s == S_DEC_RUN);
  endfunction

  always_comb begin
    nxt      = state;
    post     = 1'b0;
    ptype    = M_NONE;
    pdata    = '0;
    launch   = '0;
    abort    = 1'b0;
    err_set  = 1'b0;
    consume  = 1'b0;
    last_n   = last_q;
    load_job = 1'b0;
    if (state == S_APPRST) begin
      nxt = S_DONE;
    end else if (fin_any && !out_valid) begin
      consume = 1'b1;
      case (state)
        S_CERT_RUN: begin
          if (ok_any) nxt = S_WIMG;
          else begin
            post = 1'b1; ptype = M_RESULT; pdata = rcode(RC_CERT); nxt = S_WCERT;
          end
        end
        S_HASH_RUN: begin
          if (!ok_any) begin
            post = 1'b1; ptype = M_RESULT; pdata = rcode(RC_HASH); nxt = S_WCERT;
          end else if (last_q) begin
            launch[E_CMP] = 1'b1; nxt = S_CMP_RUN;
          end else nxt = S_WIMG;
        end
        S_CMP_RUN: begin
          if (!ok_any) begin
            post = 1'b1; ptype = M_RESULT; pdata = rcode(RC_HASH); nxt = S_WCERT;
          end else if (dec_en) begin
            launch[E_DEC] = 1'b1; nxt = S_DEC_RUN;
          end else begin
            post = 1'b1; ptype = M_RESULT; pdata = rcode(RC_PASS); nxt = S_WRACK;
          end
        end
        S_DEC_RUN: begin
          post  = 1'b1;
          ptype = M_RESULT;
          if (ok_any) begin pdata = rcode(RC_PASS); nxt = S_WRACK; end
          else begin pdata = rcode(RC_DEC); nxt = S_WCERT; end
        end
        default: ;
      endcase
    end else if (acc) begin
      if (in_type == M_GETID && state != S_HELLO) begin
        post = 1'b1; ptype = M_SOCID; pdata = soc_id;
      end else if (in_type == M_CANCEL && cancel_state(state)) begin
        abort = 1'b1; post = 1'b1; ptype = M_CACK; nxt = S_WCERT;
      end else begin
        case (state)
          S_HELLO: if (in_type == M_HELLO) nxt = S_WCERT; else err_set = 1'b1;
          S_WCERT: begin
            if (in_type == M_CERT) begin
              launch[E_CERT] = 1'b1; load_job = 1'b1; nxt = S_CERT_RUN;
            end else err_set = 1'b1;
          end
          S_WIMG: begin
            if (in_type == M_IMAGE) begin
              launch[E_HASH] = 1'b1; load_job = 1'b1; last_n = in_last; nxt = S_HASH_RUN;
            end else err_set = 1'b1;
          end
          S_WRACK: if (in_type == M_RACK) nxt = S_APPRST; else err_set = 1'b1;
          default: err_set = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_HELLO;
      dec_en    <= 1'b0;
      last_q    <= 1'b0;
      job_word  <= '0;
      eng_abort <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      state     <= nxt;
      last_q    <= last_n;
      eng_abort <= abort;
      if (load_job) job_word <= in_data;
      if (e_busy[E_CERT] && cert_done && !abort) dec_en <= cert_decrypt;
      if (err_set) err_flag <= 1'b1;
    end
  end

  assign app_rst      = (state == S_APPRST);
  assign app_boot_vec = BOOT_VEC;
endmodule

// File: rtl/boot_handshake_seq_chk.sv
module boot_handshake_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    in_type,
  input logic          out_valid,
  input logic          out_ready,
  input logic [3:0]    out_type,
  input logic [DW-1:0] out_data,
  input logic          cert_start,
  input logic          hash_start,
  input logic          cmp_done,
  input logic          cmp_pass,
  input logic          dec_start,
  input logic          app_rst,
  input logic          err_flag
);
  logic hash_ok, rack_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hash_ok   <= 1'b0;
      rack_seen <= 1'b0;
    end else begin
      if (cert_start) hash_ok <= 1'b0;
      else if (cmp_done && cmp_pass) hash_ok <= 1'b1;
      if (in_valid && in_ready && in_type == 4'd5) rack_seen <= 1'b1;
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_data));
  // R3
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R4
  cert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cert_start |=> !cert_start);
  // R5
  hash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start);
  // R7
  dec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |-> hash_ok);
  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_rst |=> !app_rst);
  // R8
  rst_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_rst |-> rack_seen);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind boot_handshake_seq boot_handshake_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_type(in_type), .out_valid(out_valid), .out_ready(out_ready),
  .out_type(out_type), .out_data(out_data), .cert_start(cert_start),
  .hash_start(hash_start), .cmp_done(cmp_done), .cmp_pass(cmp_pass),
  .dec_start(dec_start), .app_rst(app_rst), .err_flag(err_flag)
);

// File: tb/boot_handshake_seq_tb_top.sv
`timescale 1ns/1ps
module boot_handshake_seq_tb_top;
  localparam int DW = 32;
  localparam int VW = 32;
  localparam logic [DW-1:0] SOCID = 32'h5A1D_0C37;
  // scenario: {cert_ok, dec_flag, nchunks[1:0], cmp_ok, dec_ok, code[1:0]}
  localparam logic [7:0] SCN [0:4] = '{
    8'b0000_0001, 8'b1010_0010, 8'b1101_1011, 8'b1011_0010, 8'b1110_1100
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [3:0] in_type = 0;
  logic [DW-1:0] in_data = 0;
  logic cert_done = 0, cert_pass = 0, cert_decrypt = 0, hash_done = 0;
  logic cmp_done = 0, cmp_pass = 0, dec_done = 0, dec_pass = 0;
  logic in_ready, out_valid, cert_start, hash_start, cmp_start, dec_start;
  logic eng_abort, app_rst, err_flag;
  logic [3:0] out_type;
  logic [DW-1:0] out_data, job_word;
  logic [VW-1:0] app_boot_vec;
  int n_chk = 0, n_fail = 0, n_hash = 0, n_cmp = 0, n_dec = 0;

  always #10 clk = ~clk;

  boot_handshake_seq #(.DW(DW), .VW(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_data(out_data), .soc_id(SOCID), .job_word(job_word),
    .cert_start(cert_start), .cert_done(cert_done), .cert_pass(cert_pass),
    .cert_decrypt(cert_decrypt), .hash_start(hash_start), .hash_done(hash_done),
    .cmp_start(cmp_start), .cmp_done(cmp_done), .cmp_pass(cmp_pass),
    .dec_start(dec_start), .dec_done(dec_done), .dec_pass(dec_pass),
    .eng_abort(eng_abort), .app_rst(app_rst), .app_boot_vec(app_boot_vec),
    .err_flag(err_flag)
  );

  always @(posedge clk) begin
    if (hash_start) n_hash++;
    if (cmp_start)  n_cmp++;
    if (dec_start)  n_dec++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] t, input logic [DW-1:0] d, input logic l);
    @(negedge clk);
    in_valid = 1; in_type = t; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_last = 0;
  endtask

  task automatic expect_out(input logic [3:0] t, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    out_ready = 1;
    for (int k = 0; k < 100 && !out_valid; k++) @(negedge clk);
    chk(out_valid && out_type == t && out_data == d, req, {out_valid, out_type, out_data}, {1'b1, t, d});
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  task automatic eng_reply(input int idx, input logic p, input logic f);
    logic [3:0] sv;
    @(negedge clk);
    sv = {dec_start, cmp_start, hash_start, cert_start};
    for (int k = 0; k < 100 && !sv[idx]; k++) begin
      @(negedge clk);
      sv = {dec_start, cmp_start, hash_start, cert_start};
    end
    case (idx)
      0: begin cert_done = 1; cert_pass = p; cert_decrypt = f; end
      2: begin cmp_done = 1; cmp_pass = p; end
      default: begin dec_done = 1; dec_pass = p; end
    endcase
    @(negedge clk);
    cert_done = 0; cmp_done = 0; dec_done = 0;
  endtask

  task automatic quiet(input int n, input string req);
    logic seen;
    seen = 0;
    repeat (n) begin @(negedge clk); if (out_valid) seen = 1; end
    chk(!seen, req, {63'd0, seen}, 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready && !out_valid && !app_rst && !err_flag, "R1 reset",
        {in_ready, out_valid, app_rst, err_flag}, 4'b1000);
    // R1/R11: GET_SOC_ID before HELLO is dropped, sets error, no reply
    send(4'd4, 0, 0);
    quiet(4, "R1 no reply before HELLO");
    chk(err_flag, "R11 error set", err_flag, 1);
    repeat (5) @(negedge clk);
    chk(err_flag, "R11 error sticky", err_flag, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk(!err_flag, "R11 cleared by reset", err_flag, 0);

    // R9 / R2: SOC_ID reply code 8 with identity
    send(4'd1, 0, 0);
    send(4'd4, 0, 0);
    expect_out(4'd8, SOCID, "R9 R2 soc id");
    // R3 back-pressure hold
    send(4'd4, 0, 0);
    repeat (4) @(negedge clk);
    chk(out_valid && out_type == 4'd8 && !in_ready, "R3 hold",
        {out_valid, out_type, in_ready}, {1'b1, 4'd8, 1'b0});
    expect_out(4'd8, SOCID, "R3 drained");

    // R10 cancel during certificate check, late done ignored
    send(4'd2, 32'hCE57_0001, 0);
    send(4'd6, 0, 0);
    @(negedge clk);
    chk(eng_abort, "R10 abort pulse", eng_abort, 1);
    expect_out(4'd10, 0, "R10 cancel ack");
    @(negedge clk); cert_done = 1; cert_pass = 1; @(negedge clk); cert_done = 0;
    quiet(5, "R10 late done ignored");
    send(4'd3, 32'h1, 1);
    repeat (3) @(negedge clk);
    chk(n_hash == 0 && !out_valid, "R10 still waiting for certificate",
        {n_hash[31:0], 31'd0, out_valid}, 0);

    // R12 engine result held behind pending reply
    send(4'd2, 32'hCE57_0002, 0);
    send(4'd4, 0, 0);
    @(negedge clk); cert_done = 1; cert_pass = 0; @(negedge clk); cert_done = 0;
    repeat (4) @(negedge clk);
    chk(out_valid && out_type == 4'd8, "R12 reply first", out_type, 8);
    expect_out(4'd8, SOCID, "R12 soc id");
    expect_out(4'd9, 1, "R12 R4 cert fail result");

    // R4-R7 scenario table
    for (int s = 0; s < 5; s++) begin
      int nch, base_cmp, base_dec;
      logic [DW-1:0] cd;
      nch = int'(SCN[s][5:4]);
      base_cmp = n_cmp; base_dec = n_dec;
      cd = 32'hCE00_0000 + DW'(s);
      send(4'd2, cd, 0);
      @(negedge clk);
      chk(cert_start && job_word == cd, "R4 cert start", {cert_start, job_word}, {1'b1, cd});
      cert_done = 1; cert_pass = SCN[s][7]; cert_decrypt = SCN[s][6];
      @(negedge clk); cert_done = 0;
      if (SCN[s][7]) begin
        for (int c = 0; c < nch; c++) begin
          logic [DW-1:0] hd;
          hd = 32'hA000_0000 + DW'(s * 16 + c);
          send(4'd3, hd, c == nch - 1);
          @(negedge clk);
          chk(hash_start && job_word == hd, "R5 chunk hashed", {hash_start, job_word}, {1'b1, hd});
          hash_done = 1; @(negedge clk); hash_done = 0;
          if (c != nch - 1) begin
            repeat (3) @(negedge clk);
            chk(n_cmp == base_cmp, "R6 no compare before last", n_cmp, base_cmp);
          end
        end
        eng_reply(2, SCN[s][3], 0);
        if (SCN[s][3] && SCN[s][6]) eng_reply(3, SCN[s][2], 0);
      end
      expect_out(4'd9, DW'(SCN[s][1:0]), "R4 R6 R7 result code");
      chk(n_cmp == base_cmp + (SCN[s][7] ? 1 : 0), "R6 one compare", n_cmp, base_cmp + 1);
      chk(n_dec == base_dec + ((SCN[s][7] && SCN[s][6] && SCN[s][3]) ? 1 : 0),
          "R7 decrypt gating", n_dec, base_dec);
    end

    // R8 handoff: wrong type ignored, then RESULT_ACK -> one-cycle reset
    send(4'd3, 32'h77, 1);
    repeat (3) @(negedge clk);
    chk(!app_rst && !out_valid && err_flag, "R8 R11 no reset without ack",
        {app_rst, out_valid, err_flag}, 3'b001);
    send(4'd5, 0, 0);
    @(negedge clk);
    chk(app_rst && app_boot_vec == 0, "R8 reset pulse vector 0", {app_rst, app_boot_vec}, {1'b1, 32'd0});
    @(negedge clk);
    chk(!app_rst && !in_ready, "R8 single pulse then idle", {app_rst, in_ready}, 2'b00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule